// File: doc/BRIEF.md
# Gear-Shifting PI Loop Filter

This block is the digital loop filter of a phase-locked loop. Once per reference cycle a valid strobe delivers a signed phase-error sample. The filter turns that sample into a signed oscillator fine-tuning word. The filter has a proportional path, an integral path and a cascade of four single-pole IIR smoothing stages.

There are two operating modes. In acquisition the loop is type-I: only the proportional path drives the output, with a large gain for wide bandwidth, and the IIR cascade is bypassed. In tracking the integral path and the IIR cascade are engaged and the gains are smaller, so the bandwidth is narrower. Every gain is a power of two, set by a 4-bit shift code.

The mode input is sampled only on valid samples. When the sampled mode differs from the active mode, that sample becomes a gear-shift sample. On it the tuning word is held. The integrator is preloaded so that the proportional path of the new mode, plus the integrator, reproduces the held word. The IIR stages are loaded with the held word. The output therefore shows no step at the switch.

Top module: `gear_loop_filter`

## Requirements
- R1: While reset is asserted, the tuning word, the integrator and every IIR stage are cleared to zero, and the active mode becomes acquisition.
- R2: A cycle with the valid strobe low changes nothing. This includes cycles where the mode input or the gain codes change: neither is sampled and the tuning word stays constant.
- R3: On a valid acquisition sample with error e, the tuning word one clock later is sat(e * 2^acqPropShift + I), where I is the integrator. The integrator is held. The IIR stages are bypassed.
- R4: On a valid tracking sample, the integrator becomes I' = sat(I + e * 2^trkIntShift). The PI sum is sat(e * 2^trkPropShift + I').
- R5: In tracking, each of the four IIR stages computes y <= y + ((x - y) >>> k). Stage i takes its k from iirShift[4i+3:4i]. Stage 0 is fed by the PI sum of the same sample. Stage i>0 is fed by the value stage i-1 held before the update. The tuning word is the updated value of stage 3.
- R6: On a valid sample with trackMode=1 while the active mode is acquisition, the tuning word is held. The integrator is preloaded with sat(tuningWord - e * 2^trkPropShift). All IIR stages are loaded with the tuning word. Tracking becomes active.
- R7: On a valid sample with trackMode=0 while tracking is active, the tuning word is held. The integrator is preloaded with sat(tuningWord - e * 2^acqPropShift). Acquisition becomes active, and later acquisition samples use the preloaded integrator.
- R8: The integrator and the PI sum saturate at the signed limits of the tuning-word width (-2^(TW_W-1) and 2^(TW_W-1)-1) instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| phErr | input | PE_W | Signed phase-error sample |
| phValid | input | 1 | Strobe marking a new phase-error sample |
| trackMode | input | 1 | Requested mode: 0 acquisition, 1 tracking |
| acqPropShift | input | SHW | Proportional gain exponent used in acquisition |
| trkPropShift | input | SHW | Proportional gain exponent used in tracking |
| trkIntShift | input | SHW | Integral gain exponent used in tracking |
| iirShift | input | NSTAGE*SHW | Packed per-stage IIR shift codes, stage 0 in the low bits |
| tuneWord | output | TW_W | Signed oscillator fine-tuning word |

## Verification
Four properties are checked on every cycle:
- the tuning word never moves on a cycle without a valid sample;
- it holds across any gear-shift sample, in either direction;
- two back-to-back acquisition samples with equal error and gain give the same word;
- reset always leaves the word at zero.

Some behaviours are shown only by the bench's scenarios:
- the exact arithmetic of the preload;
- the one-sample lag per IIR stage;
- the integrator clamping without wrapping;
- the return to acquisition carrying the preloaded offset.

The bench reaches these by walking a hand-computed vector table and then driving the gains to their extremes.

// File: rtl/glf_pkg.sv
package glf_pkg;

  // Strobes passed from the mode control to the datapath
  typedef struct packed {
    logic load;    // ordinary update with the active mode
    logic shift;   // gear-shift sample: hold output, preload state
    logic trk;     // active mode is tracking
    logic tgtTrk;  // mode being switched to
  } glfStrobe_t;

endpackage

// File: rtl/glf_ctrl.sv
module glf_ctrl
  import glf_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       phValid,
  input  logic       trackMode,
  output glfStrobe_t strb
);

  logic activeTrk;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      activeTrk <= 1'b0;
    end else if (phValid) begin
      activeTrk <= trackMode;
    end
  end

  always_comb begin
    strb.shift  = phValid && (trackMode != activeTrk);
    strb.load   = phValid && (trackMode == activeTrk);
    strb.trk    = activeTrk;
    strb.tgtTrk = trackMode;
  end

endmodule

// File: rtl/glf_iir_stage.sv
module glf_iir_stage #(
  parameter int W   = 16,
  parameter int SHW = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                init,
  input  logic signed [W-1:0] initVal,
  input  logic signed [W-1:0] x,
  input  logic [SHW-1:0]      k,
  output logic signed [W-1:0] y,
  output logic signed [W-1:0] yNext
);

  logic signed [W:0] diff;
  logic signed [W:0] step;
  logic signed [W:0] sumW;

  always_comb begin
    diff  = {x[W-1], x} - {y[W-1], y};
    step  = diff >>> k;
    sumW  = {y[W-1], y} + step;
    // the result lies between x and y, so it fits in W bits
    yNext = sumW[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      y <= '0;
    end else if (init) begin
      y <= initVal;
    end else if (en) begin
      y <= yNext;
    end
  end

endmodule

// File: rtl/glf_datapath.sv
module glf_datapath
  import glf_pkg::*;
#(
  parameter int PE_W   = 10,
  parameter int TW_W   = 16,
  parameter int NSTAGE = 4,
  parameter int SHW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  glfStrobe_t               strb,
  input  logic signed [PE_W-1:0]   phErr,
  input  logic [SHW-1:0]           acqPropShift,
  input  logic [SHW-1:0]           trkPropShift,
  input  logic [SHW-1:0]           trkIntShift,
  input  logic [NSTAGE*SHW-1:0]    iirShift,
  output logic signed [TW_W-1:0]   tuneWord
);

  localparam int SHMAX  = (1 << SHW) - 1;
  localparam int PWIDTH = PE_W + SHMAX;
  localparam int AW     = ((PWIDTH > TW_W) ? PWIDTH : TW_W) + 2;
  localparam longint TWMAXL = (longint'(1) <<< (TW_W - 1)) - 1;
  localparam logic signed [AW-1:0] SAT_HI = AW'(TWMAXL);
  localparam logic signed [AW-1:0] SAT_LO = -SAT_HI - AW'(1);

  function automatic logic signed [AW-1:0] scaleErr(
    input logic signed [PE_W-1:0] e,
    input logic [SHW-1:0]         s
  );
    logic signed [AW-1:0] wide;
    wide = AW'(e);
    return wide <<< s;
  endfunction

  function automatic logic signed [AW-1:0] ext(input logic signed [TW_W-1:0] v);
    return AW'(v);
  endfunction

  function automatic logic signed [TW_W-1:0] satTw(input logic signed [AW-1:0] v);
    logic signed [TW_W-1:0] r;
    if (v > SAT_HI) begin
      r = SAT_HI[TW_W-1:0];
    end else if (v < SAT_LO) begin
      r = SAT_LO[TW_W-1:0];
    end else begin
      r = v[TW_W-1:0];
    end
    return r;
  endfunction

  logic signed [TW_W-1:0] intAcc;
  logic signed [TW_W-1:0] intNext;
  logic signed [TW_W-1:0] piSum;
  logic signed [TW_W-1:0] preload;
  logic [SHW-1:0]         pSel;
  logic                   pUseTrk;
  logic signed [AW-1:0]   pTerm;
  logic signed [AW-1:0]   iTerm;

  logic signed [TW_W-1:0] yArr     [NSTAGE];
  logic signed [TW_W-1:0] yNextArr [NSTAGE];
  logic                   iirEn;

  always_comb begin
    // on a gear shift the proportional gain of the target mode is used
    pUseTrk = strb.shift ? strb.tgtTrk : strb.trk;
    pSel    = pUseTrk ? trkPropShift : acqPropShift;
    pTerm   = scaleErr(phErr, pSel);
    iTerm   = scaleErr(phErr, trkIntShift);
    intNext = strb.trk ? satTw(ext(intAcc) + iTerm) : intAcc;
    piSum   = satTw(pTerm + ext(intNext));
    preload = satTw(ext(tuneWord) - pTerm);
    iirEn   = strb.load && strb.trk;
  end

  for (genvar g = 0; g < NSTAGE; g++) begin : g_iir
    logic signed [TW_W-1:0] stageIn;
    if (g == 0) begin : g_first
      assign stageIn = piSum;
    end else begin : g_rest
      assign stageIn = yArr[g-1];
    end
    glf_iir_stage #(
      .W   (TW_W),
      .SHW (SHW)
    ) u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .en      (iirEn),
      .init    (strb.shift),
      .initVal (tuneWord),
      .x       (stageIn),
      .k       (iirShift[g*SHW +: SHW]),
      .y       (yArr[g]),
      .yNext   (yNextArr[g])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      intAcc   <= '0;
      tuneWord <= '0;
    end else if (strb.shift) begin
      intAcc   <= preload;
    end else if (strb.load) begin
      intAcc   <= intNext;
      tuneWord <= strb.trk ? yNextArr[NSTAGE-1] : piSum;
    end
  end

endmodule

// File: rtl/gear_loop_filter.sv
module gear_loop_filter
  import glf_pkg::*;
#(
  parameter int PE_W   = 10,
  parameter int TW_W   = 16,
  parameter int NSTAGE = 4,
  parameter int SHW    = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic signed [PE_W-1:0]  phErr,
  input  logic                    phValid,
  input  logic                    trackMode,
  input  logic [SHW-1:0]          acqPropShift,
  input  logic [SHW-1:0]          trkPropShift,
  input  logic [SHW-1:0]          trkIntShift,
  input  logic [NSTAGE*SHW-1:0]   iirShift,
  output logic signed [TW_W-1:0]  tuneWord
);

  glfStrobe_t strb;

  glf_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .phValid   (phValid),
    .trackMode (trackMode),
    .strb      (strb)
  );

  glf_datapath #(
    .PE_W   (PE_W),
    .TW_W   (TW_W),
    .NSTAGE (NSTAGE),
    .SHW    (SHW)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_n),
    .strb         (strb),
    .phErr        (phErr),
    .acqPropShift (acqPropShift),
    .trkPropShift (trkPropShift),
    .trkIntShift  (trkIntShift),
    .iirShift     (iirShift),
    .tuneWord     (tuneWord)
  );

endmodule

// File: rtl/glf_checker.sv
module glf_checker #(
  parameter int PE_W = 10,
  parameter int TW_W = 16,
  parameter int SHW  = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic signed [PE_W-1:0] phErr,
  input logic                   phValid,
  input logic                   trackMode,
  input logic [SHW-1:0]         acqPropShift,
  input logic signed [TW_W-1:0] tuneWord
);

  // independent view of the mode, built from the ports only
  logic                   modeSeen;
  logic                   lastAcqUpd;
  logic signed [PE_W-1:0] lastErr;
  logic [SHW-1:0]         lastGain;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      modeSeen   <= 1'b0;
      lastAcqUpd <= 1'b0;
      lastErr    <= '0;
      lastGain   <= '0;
    end else if (phValid) begin
      modeSeen   <= trackMode;
      lastAcqUpd <= !trackMode && !modeSeen;
      lastErr    <= phErr;
      lastGain   <= acqPropShift;
    end
  end

  // R1: reset leaves the tuning word at zero
  a_r1_reset_zero: assert property (@(posedge clk)
    !rst_n |=> (tuneWord == '0));

  // R2: no valid sample, no change
  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !phValid |=> $stable(tuneWord));

  // R6 and R7: the word is held across a gear shift in either direction
  a_r6_shift_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (phValid && (trackMode != modeSeen)) |=> $stable(tuneWord));

  // R3: type-I acquisition with frozen integrator is memoryless in the error
  a_r3_acq_repeat: assert property (@(posedge clk) disable iff (!rst_n)
    (phValid && !trackMode && !modeSeen && lastAcqUpd &&
     (phErr == lastErr) && (acqPropShift == lastGain)) |=> $stable(tuneWord));

endmodule

bind gear_loop_filter glf_checker #(
  .PE_W (PE_W),
  .TW_W (TW_W),
  .SHW  (SHW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .phErr        (phErr),
  .phValid      (phValid),
  .trackMode    (trackMode),
  .acqPropShift (acqPropShift),
  .tuneWord     (tuneWord)
);

// File: tb/sim_gear_loop_filter.sv
module sim_gear_loop_filter;

  localparam int CLK_PERIOD = 10;
  localparam int PE_W = 10;
  localparam int TW_W = 16;
  localparam int NSTAGE = 4;
  localparam int SHW = 4;
  localparam int NVEC = 11;

  typedef struct packed {
    logic                   v;
    logic                   m;
    logic signed [PE_W-1:0] e;
    logic signed [TW_W-1:0] exp;
  } vec_t;

  // gains: acqProp=3, trkProp=1, trkInt=0, stage0 k=1, stages 1..3 k=0
  localparam vec_t VEC [NVEC] = '{
    '{1'b1, 1'b0,  10'sd5,   16'sd40},   // acq: 5*8
    '{1'b0, 1'b0,  10'sd100, 16'sd40},   // idle hold
    '{1'b1, 1'b0, -10'sd3,  -16'sd24},   // acq: -3*8
    '{1'b1, 1'b1,  10'sd4,  -16'sd24},   // shift to tracking, held
    '{1'b1, 1'b1,  10'sd4,  -16'sd24},   // tracking, pipeline lag
    '{1'b1, 1'b1,  10'sd0,  -16'sd24},
    '{1'b1, 1'b1,  10'sd0,  -16'sd24},
    '{1'b1, 1'b1,  10'sd0,  -16'sd22},   // first PI value reaches stage 3
    '{1'b1, 1'b0,  10'sd2,  -16'sd22},   // shift back to acq, held
    '{1'b1, 1'b0,  10'sd2,  -16'sd22},   // 16 + preload(-38)
    '{1'b1, 1'b0, -10'sd1,  -16'sd46}    // -8 - 38
  };

  localparam string TAG [NVEC] = '{
    "R3", "R2", "R3", "R6", "R5", "R5", "R5", "R4 R5", "R7", "R7", "R7"
  };

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic signed [PE_W-1:0] phErr = '0;
  logic                   phValid = 1'b0;
  logic                   trackMode = 1'b0;
  logic [SHW-1:0]         acqPropShift = 4'd3;
  logic [SHW-1:0]         trkPropShift = 4'd1;
  logic [SHW-1:0]         trkIntShift = 4'd0;
  logic [NSTAGE*SHW-1:0]  iirShift = 16'h0001;
  logic signed [TW_W-1:0] tuneWord;

  int nTests = 0;
  int nFail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  gear_loop_filter #(
    .PE_W (PE_W), .TW_W (TW_W), .NSTAGE (NSTAGE), .SHW (SHW)
  ) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .phErr        (phErr),
    .phValid      (phValid),
    .trackMode    (trackMode),
    .acqPropShift (acqPropShift),
    .trkPropShift (trkPropShift),
    .trkIntShift  (trkIntShift),
    .iirShift     (iirShift),
    .tuneWord     (tuneWord)
  );

  task automatic check(input string tag, input logic signed [TW_W-1:0] exp);
    nTests++;
    if (tuneWord !== exp) begin
      nFail++;
      $display("FAIL %s: tuneWord got %0d expected %0d", tag, tuneWord, exp);
    end
  endtask

  // called at a falling edge; returns at the next falling edge
  task automatic step(input logic v, input logic m, input logic signed [PE_W-1:0] e);
    phValid = v;
    trackMode = m;
    phErr = e;
    @(posedge clk);
    @(negedge clk);
    phValid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 reset", 16'sd0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i].v, VEC[i].m, VEC[i].e);
      check(TAG[i], VEC[i].exp);
    end

    // R2: mode and gains change without a valid strobe: nothing happens
    trackMode = 1'b1;
    acqPropShift = 4'd9;
    repeat (3) @(negedge clk);
    check("R2 idle mode change", -16'sd46);
    acqPropShift = 4'd3;
    step(1'b1, 1'b0, 10'sd1);
    check("R2 no shift taken", -16'sd30);

    // R8: output saturation in acquisition
    acqPropShift = 4'd15;
    step(1'b1, 1'b0, 10'sd511);
    check("R8 positive clamp", 16'sd32767);
    step(1'b1, 1'b0, -10'sd512);
    check("R8 negative clamp", -16'sd32768);

    // R6: shift into tracking with pure-delay IIR stages
    trkPropShift = 4'd0;
    trkIntShift = 4'd15;
    iirShift = 16'h0000;
    step(1'b1, 1'b1, 10'sd0);
    check("R6 shift hold", -16'sd32768);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, 10'sd511);
    check("R8 integrator clamp high", 16'sd32767);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b1, -10'sd1);
    check("R8 integrator did not wrap", -16'sd2);

    // R1: reset from a non-zero state
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 reset clears", 16'sd0);
    acqPropShift = 4'd2;
    step(1'b1, 1'b0, 10'sd3);
    check("R1 acq after reset", 16'sd12);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule